// File: doc/BRIEF.md
# Power-Domain Status and Configuration Register

This block holds one 32-bit power-management word whose fields belong to three reset domains: the battery (real-time-clock) well, the suspend well and the main well. A real-time-clock well reset also resets the suspend well, and a suspend well reset also resets the main well. Each field is reset only by its own domain, so a field can report or outlive a reset of a narrower domain. Software reads the word with a read strobe and writes it with a write strobe. Single-cycle event pulses record which kind of platform reset took place, and hardware status inputs set sticky flags that software clears by writing 1.

Two lock state machines guard the lockable fields. Each machine has the states `LK_OPEN` and `LK_SHUT`. Its only transition, *arm*, goes from `LK_OPEN` to `LK_SHUT` when its set request is seen on a clock edge. `LK_SHUT` loops on itself, and only a suspend well reset returns the machine to `LK_OPEN`. The software lock is armed by writing 1 to bit 8, and it protects the wake-disable bit 15. The configuration lock is armed by the `cfg_lock_in` pin, and it protects the timing fields 12, 11:10, 5:4 and 3. A lock takes effect from the cycle after it is armed.

Top module: `pm_status_reg`

## Requirements
- R1: After a real-time-clock well reset the word reads 0x20014000. Bits 29, 16 and 14 are 1 and every other bit is 0.
- R2: Bits 31, 26, 25, 22, 21, 20, 19, 17 and 13 always read 0, and writes to them have no effect.
- R3: With no lock armed, a write stores the plain fields 30:27, 23, 7:6, 2:1 and 0, the wake-disable bit 15 and the lockable fields 12, 11:10, 5:4 and 3. The write is visible from the next clock edge.
- R4: A main well reset clears bits 7:6 and 2:1 and leaves every other field unchanged, including the scratch bit 23.
- R5: A suspend well reset sets bit 16 and bit 29, and clears the other suspend-domain fields and both locks. The battery-fail bit 14 changes only on a real-time-clock well reset, which sets it to 1.
- R6: The status bits 24, 18, 16, 14 and 9 clear when 1 is written to them. Writing 0 to them leaves them unchanged.
- R7: A hardware set and a write-1 clear of the same status bit in the same cycle leave the bit at 1.
- R8: A global-reset pulse sets bit 24 only. A host-reset pulse sets bit 9 only. A pulse on the width-violation input sets bit 18.
- R9: Writing 1 to bit 8 arms the software lock. Writes of 0 to bit 8 have no effect, and while the lock is armed, writes to bit 15 have no effect. Only a suspend well reset (or a wider one) clears the lock.
- R10: A pulse on `cfg_lock_in` arms the configuration lock. While it is armed, writes to bits 12, 11:10, 5:4 and 3 have no effect. Only a suspend well reset (or a wider one) clears the lock.
- R11: `rd_data` shows the current word in the same cycle that `rd_en` is high, and reads 0 when `rd_en` is low. A read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rtc_rst_n | input | 1 | Battery well reset, active low, asynchronous |
| sus_rst_n | input | 1 | Suspend well reset, active low, asynchronous |
| main_rst_n | input | 1 | Main well reset, active low, asynchronous |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational |
| glb_rst_evt | input | 1 | Pulse: a global reset occurred |
| host_rst_evt | input | 1 | Pulse: a host partition reset occurred |
| s4_width_viol | input | 1 | Pulse: a minimum assertion width was violated |
| cfg_lock_in | input | 1 | Pulse: arm the configuration lock |

## Verification
The assertions check the following on every cycle:
- an armed lock state machine stays in `LK_SHUT`;
- a hardware set always leaves its status bit at 1;
- reserved bits never read as 1;
- the locked configuration fields never move on a write;
- a plain read leaves the word unchanged.

Only the bench scenarios can show the reset-domain behaviour: which fields survive main, suspend and real-time-clock resets, and that a lock reopens after a suspend reset. The bench's reference model also compares the word after every clock.

// File: rtl/pm_stat_pkg.sv
package pm_stat_pkg;
    localparam int unsigned REG_W = 32;
    localparam int unsigned N_STS = 5;

    typedef enum logic {LK_OPEN = 1'b0, LK_SHUT = 1'b1} lock_state_t;

    localparam logic [REG_W-1:0] MAIN_RW_MASK = 32'h0000_00C6;
    localparam logic [REG_W-1:0] SUS_RW_MASK  = 32'h7880_0001;
    localparam logic [REG_W-1:0] SUS_RW_INIT  = 32'h2000_0000;
    localparam logic [REG_W-1:0] CFG_MASK     = 32'h0000_1C38;
    localparam logic [REG_W-1:0] RSV_MASK     = 32'h867A_2000;
    localparam int unsigned      WAKE_BIT     = 15;
    localparam int unsigned      SWLK_BIT     = 8;

    // status flags: global reset, width violation, suspend fail, battery fail, host reset
    localparam int unsigned STS_POS [N_STS] = '{24, 18, 16, 14, 9};
    localparam logic [N_STS-1:0] STS_INIT   = 5'b01100;
    localparam logic [N_STS-1:0] STS_RTC    = 5'b01000;
endpackage

// File: rtl/pm_lock_fsm.sv
module pm_lock_fsm
    import pm_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    output logic locked_o
);
    lock_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (set_i) state_d = LK_SHUT;
            LK_SHUT: state_d = LK_SHUT;
            default: state_d = LK_OPEN;
        endcase
    end

    assign locked_o = (state_q == LK_SHUT);

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);
endmodule

// File: rtl/pm_w1c_bit.sv
module pm_w1c_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= RST_VAL;
        else if (hw_set) q <= 1'b1;
        else if (clr)    q <= 1'b0;
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> q);
endmodule

// File: rtl/pm_status_reg.sv
module pm_status_reg
    import pm_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rtc_rst_n,
    input  logic              sus_rst_n,
    input  logic              main_rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rd_data,
    input  logic              glb_rst_evt,
    input  logic              host_rst_evt,
    input  logic              s4_width_viol,
    input  logic              cfg_lock_in
);
    logic rst_sus, rst_main;
    assign rst_sus  = sus_rst_n & rtc_rst_n;
    assign rst_main = main_rst_n & rst_sus;

    logic [REG_W-1:0] main_q, sus_q, cfg_q, sts_word, reg_val;
    logic             wake_q, sw_locked, cfg_locked;
    logic [N_STS-1:0] sts_set, sts_q;

    always_ff @(posedge clk or negedge rst_main) begin
        if (!rst_main)  main_q <= '0;
        else if (wr_en) main_q <= wr_data & MAIN_RW_MASK;
    end

    always_ff @(posedge clk or negedge rst_sus) begin
        if (!rst_sus)   sus_q <= SUS_RW_INIT;
        else if (wr_en) sus_q <= wr_data & SUS_RW_MASK;
    end

    always_ff @(posedge clk or negedge rst_sus) begin
        if (!rst_sus)                wake_q <= 1'b0;
        else if (wr_en && !sw_locked) wake_q <= wr_data[WAKE_BIT];
    end

    always_ff @(posedge clk or negedge rst_sus) begin
        if (!rst_sus)                 cfg_q <= '0;
        else if (wr_en && !cfg_locked) cfg_q <= wr_data & CFG_MASK;
    end

    pm_lock_fsm u_swlk (
        .clk(clk), .rst_n(rst_sus),
        .set_i(wr_en & wr_data[SWLK_BIT]), .locked_o(sw_locked)
    );

    pm_lock_fsm u_cfglk (
        .clk(clk), .rst_n(rst_sus),
        .set_i(cfg_lock_in), .locked_o(cfg_locked)
    );

    assign sts_set = {host_rst_evt, 1'b0, 1'b0, s4_width_viol, glb_rst_evt};

    for (genvar i = 0; i < N_STS; i++) begin : g_sts
        pm_w1c_bit #(.RST_VAL(STS_INIT[i])) u_bit (
            .clk(clk),
            .rst_n(STS_RTC[i] ? rtc_rst_n : rst_sus),
            .hw_set(sts_set[i]),
            .clr(wr_en & wr_data[STS_POS[i]]),
            .q(sts_q[i])
        );
    end

    always_comb begin
        sts_word = '0;
        for (int i = 0; i < N_STS; i++) sts_word[STS_POS[i]] = sts_q[i];
    end

    always_comb begin
        reg_val = main_q | sus_q | cfg_q | sts_word;
        reg_val[WAKE_BIT] = wake_q;
        reg_val[SWLK_BIT] = sw_locked;
    end

    assign rd_data = rd_en ? reg_val : '0;

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n)
        (rd_data & RSV_MASK) == '0);

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_sus)
        (cfg_locked && wr_en) |=> $stable(reg_val & CFG_MASK));

    // R11
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_main)
        (rd_en && !wr_en && !glb_rst_evt && !host_rst_evt && !s4_width_viol)
        |=> $stable(reg_val));
endmodule

// File: tb/sim_pm_status_reg.sv
module sim_pm_status_reg;
    localparam time PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rtc_rst_n = 1'b0, sus_rst_n = 1'b1, main_rst_n = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b1;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        glb_rst_evt = 1'b0, host_rst_evt = 1'b0;
    logic        s4_width_viol = 1'b0, cfg_lock_in = 1'b0;

    int errors = 0, checks = 0;
    bit started = 0, done = 0;

    logic [31:0] m;
    bit          m_cfglk;

    always #(PERIOD/2) clk = ~clk;

    pm_status_reg u0 (
        .clk(clk), .rtc_rst_n(rtc_rst_n), .sus_rst_n(sus_rst_n), .main_rst_n(main_rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .glb_rst_evt(glb_rst_evt), .host_rst_evt(host_rst_evt),
        .s4_width_viol(s4_width_viol), .cfg_lock_in(cfg_lock_in)
    );

    task automatic apply_resets();
        if (!main_rst_n) m &= ~32'h0000_00C6;
        if (!sus_rst_n) begin
            m = (m & 32'h0000_4000) | 32'h2001_0000;
            m_cfglk = 0;
        end
        if (!rtc_rst_n) begin
            m = 32'h2001_4000;
            m_cfglk = 0;
        end
    endtask

    always @(posedge clk) begin
        logic [31:0] n;
        n = m;
        if (wr_en) begin
            n = (n & ~32'h7880_00C7) | (wr_data & 32'h7880_00C7);
            if (!m[8]) n[15] = wr_data[15];
            if (!m_cfglk) n = (n & ~32'h0000_1C38) | (wr_data & 32'h0000_1C38);
            if (wr_data[8]) n[8] = 1'b1;
            n &= ~(wr_data & 32'h0105_4200);
        end
        if (glb_rst_evt) n[24] = 1'b1;
        if (host_rst_evt) n[9] = 1'b1;
        if (s4_width_viol) n[18] = 1'b1;
        m = n;
        if (cfg_lock_in) m_cfglk = 1;
        apply_resets();
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R11: on every clock, the read port shows the model word
    always @(negedge clk) begin
        if (started && !done) check("R11", rd_data, rd_en ? m : 32'h0);
    end

    task automatic drive(bit we, logic [31:0] wd, bit ge = 0, bit he = 0, bit sv = 0, bit cl = 0);
        wr_en = we; wr_data = wd; glb_rst_evt = ge; host_rst_evt = he;
        s4_width_viol = sv; cfg_lock_in = cl;
        @(posedge clk); #1;
        wr_en = 0; wr_data = '0; glb_rst_evt = 0; host_rst_evt = 0;
        s4_width_viol = 0; cfg_lock_in = 0;
    endtask

    task automatic expect_val(string req, logic [31:0] mask, logic [31:0] exp);
        @(negedge clk); #1;
        check(req, rd_data & mask, exp);
        @(posedge clk); #1;
    endtask

    task automatic pulse_reset(int which);
        if (which == 0) main_rst_n = 0;
        else if (which == 1) sus_rst_n = 0;
        else rtc_rst_n = 0;
        apply_resets();
        @(posedge clk); #1;
        main_rst_n = 1; sus_rst_n = 1; rtc_rst_n = 1;
    endtask

    initial begin
        m = '0; m_cfglk = 0;
        apply_resets();
        repeat (2) @(posedge clk);
        #1;
        rtc_rst_n = 1;
        started = 1;
        expect_val("R1", 32'hFFFF_FFFF, 32'h2001_4000);

        drive(1, 32'hFFFF_FFFF);
        expect_val("R3", 32'hFFFF_FFFF, 32'h7880_9DFF);
        expect_val("R2", 32'h867A_2000, 32'h0);

        drive(1, 32'h0);
        expect_val("R9", 32'hFFFF_FFFF, 32'h0000_8100);

        drive(1, 32'h0000_1C38);
        drive(0, 32'h0, 0, 0, 0, 1);
        drive(1, 32'h0);
        expect_val("R10", 32'h0000_1C38, 32'h0000_1C38);

        drive(0, 32'h0, 1);
        expect_val("R8", 32'h0100_0200, 32'h0100_0000);
        drive(0, 32'h0, 0, 1);
        expect_val("R8", 32'h0100_0200, 32'h0100_0200);
        drive(1, 32'h0);
        expect_val("R6", 32'h0100_0200, 32'h0100_0200);
        drive(1, 32'h0100_0000);
        expect_val("R6", 32'h0100_0200, 32'h0000_0200);

        drive(1, 32'h0000_0200, 0, 1);
        expect_val("R7", 32'h0000_0200, 32'h0000_0200);
        drive(0, 32'h0, 0, 0, 1);
        expect_val("R8", 32'h0004_0000, 32'h0004_0000);
        drive(1, 32'h0004_0000, 0, 0, 1);
        expect_val("R7", 32'h0004_0000, 32'h0004_0000);
        drive(1, 32'h0004_0200);
        expect_val("R6", 32'h0004_0200, 32'h0);

        drive(1, 32'h0080_00C7);
        pulse_reset(0);
        expect_val("R4", 32'hFFFF_FFFF, 32'h0080_9D39);

        drive(1, 32'h0080_0000);
        pulse_reset(1);
        expect_val("R5", 32'hFFFF_FFFF, 32'h2001_0000);
        drive(1, 32'h0000_9C38);
        expect_val("R9", 32'h0000_8100, 32'h0000_8000);
        expect_val("R10", 32'h0000_1C38, 32'h0000_1C38);

        pulse_reset(2);
        expect_val("R5", 32'h0000_4000, 32'h0000_4000);

        drive(1, 32'h7880_00C7);
        rd_en = 0;
        expect_val("R11", 32'hFFFF_FFFF, 32'h0);
        rd_en = 1;
        expect_val("R11", 32'hFFFF_FFFF, 32'h7881_40C7);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule